// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Router

This block gathers level-sensitive interrupt requests from five sources: two general I/O controllers, an Ethernet controller, a serial controller and a non-maskable source. It places each request on one bit of an 8-bit pending register and presents the CPU with a 3-bit priority level and an 8-bit autovector number for the most urgent pending bit. A mode pin chooses between two routing tables. In the high mode the Ethernet request does not enter the pending register and is instead passed out on a separate reroute line, where a second interrupt controller can pick it up.

The non-maskable request is produced inside the block. A one-cycle button strobe starts a hold window of one tenth of a second, measured in clock cycles from the `CLK_HZ` parameter. The request stays asserted for that whole window, and a further strobe during the window starts the window again. The pending bits carry no memory of past events: each mapped bit simply tracks its source, so software never has to acknowledge anything.

Top module: `irq_prio_router`

## Requirements
- R1: With the registered mode high, the sources map as follows: first I/O controller to pending bit 0 (level 1, vector 25), second I/O controller to bit 1 (level 2, vector 26), serial controller to bit 3 (level 4, vector 28), non-maskable request to bit 6 (level 7, vector 31).
- R2: With the registered mode high, the Ethernet request leaves the pending register untouched and `enet_reroute_o` equals `enet_req_i` combinationally. With the registered mode low, `enet_reroute_o` is 0.
- R3: With the registered mode low, the sources map as follows: first I/O controller to bit 5 (level 6, vector 30), second I/O controller to bit 1, Ethernet to bit 2 (level 3, vector 27), serial controller to bit 3, non-maskable request to bit 6.
- R4: Each mapped pending bit takes the current level of its source at every clock edge, so a request that falls clears its bit and nothing is latched.
- R5: `ipl_o` is one plus the index of the highest set pending bit, and `vec_o` is that index plus 25.
- R6: When no pending bit is set, `ipl_o` and `vec_o` are both 0.
- R7: A strobe sampled high at one clock edge sets bit 6 at that edge and keeps it set for exactly HOLD = CLK_HZ/10 clock cycles after that edge. A strobe that arrives during the window starts a full new window from its own edge.
- R8: An active-low reset clears the pending register, the level and vector outputs, the registered mode (to low) and any hold window in progress, without waiting for a clock edge.
- R9: `mode_i` is registered at each edge, and the pending update at an edge uses the mode registered at the previous edge. A mode change does not flush the pending register, and a bit that has no source in the current mode keeps its value until reset.
- R10: `ipl_o` and `vec_o` are registered and change at the first clock edge after a request changes, and never between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Routing table select, registered before use |
| io0_req_i | input | 1 | First I/O controller request level |
| io1_req_i | input | 1 | Second I/O controller request level |
| enet_req_i | input | 1 | Ethernet controller request level |
| ser_req_i | input | 1 | Serial controller request level |
| nmi_strobe_i | input | 1 | Button strobe that starts the non-maskable hold window |
| ipl_o | output | 3 | Registered CPU priority level, 0 when idle |
| vec_o | output | 8 | Registered autovector number, 0 when idle |
| enet_reroute_o | output | 1 | Ethernet request forwarded in high mode |

## Verification
All sixteen combinations of the four level-sensitive requests are swept in each mode, starting with high mode straight after reset so that no stale bits hide the high-mode mapping. Within each sweep, a combination that drops a request right after one that raised it shows whether the bit follows the level, and each single-source pattern identifies exactly one pending bit through its level and vector. A pattern that raises the first I/O request in low mode, switches the mode and then drops the request tells the mode delay and the stale-bit hold apart from a flush. For the non-maskable source, a single strobe, a restarting strobe and a reset during the window measure the window length in cycles and show that a new strobe or a reset cuts the window off.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int unsigned NUM_SRC  = 5;
   localparam int unsigned PEND_W   = 8;
   localparam int unsigned LVL_W    = 3;
   localparam int unsigned VEC_W    = 8;
   localparam int unsigned VEC_BASE = 25;
   localparam int unsigned BIT_W    = $clog2(PEND_W);

   // source positions in the packed request vector
   localparam int SRC_IO0  = 0;
   localparam int SRC_IO1  = 1;
   localparam int SRC_ENET = 2;
   localparam int SRC_SER  = 3;
   localparam int SRC_NMI  = 4;

   localparam int NO_BIT = -1;

   // pending bit a source drives when the mode register is high
   function automatic int bit_for_hi(input int src);
      case (src)
         SRC_IO0:  return 0;
         SRC_IO1:  return 1;
         SRC_SER:  return 3;
         SRC_NMI:  return 6;
         default:  return NO_BIT;  // Ethernet leaves on the reroute line
      endcase
   endfunction

   // pending bit a source drives when the mode register is low
   function automatic int bit_for_lo(input int src);
      case (src)
         SRC_IO0:  return 5;
         SRC_IO1:  return 1;
         SRC_ENET: return 2;
         SRC_SER:  return 3;
         SRC_NMI:  return 6;
         default:  return NO_BIT;
      endcase
   endfunction

endpackage

// File: rtl/irq_nmi_stretch.sv
module irq_nmi_stretch #(
   parameter int unsigned HOLD_CYC = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         strobe_i,
   output logic                         active_o,
   output logic [$clog2(HOLD_CYC)-1:0]  cnt_o
);

   localparam int unsigned CNT_W = $clog2(HOLD_CYC);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

   generate
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("irq_nmi_stretch: HOLD_CYC must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   // remaining cycles after the current one; the strobe itself is the first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (strobe_i) begin
         cnt_q <= RELOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active_o = strobe_i | (cnt_q != '0);
   assign cnt_o    = cnt_q;

endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
   import irq_router_pkg::*;
#(
   parameter int unsigned N_SRC  = NUM_SRC,
   parameter int unsigned N_PEND = PEND_W
) (
   input  logic              mode_hi_i,
   input  logic [N_SRC-1:0]  src_i,
   output logic [N_PEND-1:0] upd_mask_o,
   output logic [N_PEND-1:0] upd_val_o,
   output logic              reroute_o
);

   localparam int unsigned IDX_W = $clog2(N_PEND);

   generate
      if (N_SRC != NUM_SRC) begin : g_bad_src
         $error("irq_route_map: source count must match the routing tables");
      end
      if (N_PEND < 7) begin : g_bad_pend
         $error("irq_route_map: pending register too narrow for the tables");
      end
   endgenerate

   logic [N_PEND-1:0] mask_hi, val_hi, mask_lo, val_lo;

   always_comb begin
      mask_hi = '0;
      val_hi  = '0;
      mask_lo = '0;
      val_lo  = '0;
      for (int s = 0; s < int'(N_SRC); s++) begin
         int bh;
         int bl;
         bh = bit_for_hi(s);
         bl = bit_for_lo(s);
         if (bh != NO_BIT) begin
            mask_hi[bh[IDX_W-1:0]] = 1'b1;
            val_hi[bh[IDX_W-1:0]]  = src_i[s];
         end
         if (bl != NO_BIT) begin
            mask_lo[bl[IDX_W-1:0]] = 1'b1;
            val_lo[bl[IDX_W-1:0]]  = src_i[s];
         end
      end
   end

   assign upd_mask_o = mode_hi_i ? mask_hi : mask_lo;
   assign upd_val_o  = mode_hi_i ? val_hi  : val_lo;
   assign reroute_o  = mode_hi_i & src_i[SRC_ENET];

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N_PEND   = 8,
   parameter int unsigned L_W      = 3,
   parameter int unsigned V_W      = 8,
   parameter int unsigned V_BASE   = 25
) (
   input  logic [N_PEND-1:0] pend_i,
   output logic [L_W-1:0]    lvl_o,
   output logic [V_W-1:0]    vec_o
);

   localparam int unsigned IDX_W = $clog2(N_PEND);

   generate
      if (V_BASE + N_PEND > (1 << V_W)) begin : g_bad_vec
         $error("irq_prio_enc: vector width too small for base plus bits");
      end
   endgenerate

   // one-hot marker of the highest set bit
   logic [N_PEND-1:0] top_hot;

   genvar gi;
   generate
      for (gi = 0; gi < int'(N_PEND); gi++) begin : g_top
         if (gi == int'(N_PEND) - 1) begin : g_msb
            assign top_hot[gi] = pend_i[gi];
         end else begin : g_lower
            assign top_hot[gi] = pend_i[gi] & ~(|pend_i[N_PEND-1:gi+1]);
         end
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             any;

   always_comb begin
      idx = '0;
      for (int i = 0; i < int'(N_PEND); i++) begin
         if (top_hot[i]) idx = idx | IDX_W'(i);
      end
   end

   assign any   = |pend_i;
   // the top pending bit never has a source, so the level cannot overflow
   assign lvl_o = any ? L_W'(idx + 1'b1)       : '0;
   assign vec_o = any ? V_W'(idx) + V_W'(V_BASE) : '0;

endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
   import irq_router_pkg::*;
#(
   parameter int unsigned CLK_HZ = 32_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_i,
   input  logic             io0_req_i,
   input  logic             io1_req_i,
   input  logic             enet_req_i,
   input  logic             ser_req_i,
   input  logic             nmi_strobe_i,
   output logic [LVL_W-1:0] ipl_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             enet_reroute_o
);

   localparam int unsigned HOLD_CYC = CLK_HZ / 10;
   localparam int unsigned CNT_W    = $clog2(HOLD_CYC);

   generate
      if (CLK_HZ < 20) begin : g_bad_clk
         $error("irq_prio_router: CLK_HZ too small for a two-cycle hold");
      end
   endgenerate

   logic               mode_q;
   logic               nmi_act;
   logic [CNT_W-1:0]   nmi_cnt;
   logic [NUM_SRC-1:0] src_vec;
   logic [PEND_W-1:0]  upd_mask, upd_val;
   logic [PEND_W-1:0]  pend_q, pend_d;
   logic [LVL_W-1:0]   lvl_d, ipl_q;
   logic [VEC_W-1:0]   vec_d, vec_q;

   irq_nmi_stretch #(
      .HOLD_CYC (HOLD_CYC)
   ) u_nmi (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (nmi_strobe_i),
      .active_o (nmi_act),
      .cnt_o    (nmi_cnt)
   );

   always_comb begin
      src_vec           = '0;
      src_vec[SRC_IO0]  = io0_req_i;
      src_vec[SRC_IO1]  = io1_req_i;
      src_vec[SRC_ENET] = enet_req_i;
      src_vec[SRC_SER]  = ser_req_i;
      src_vec[SRC_NMI]  = nmi_act;
   end

   irq_route_map #(
      .N_SRC  (NUM_SRC),
      .N_PEND (PEND_W)
   ) u_map (
      .mode_hi_i  (mode_q),
      .src_i      (src_vec),
      .upd_mask_o (upd_mask),
      .upd_val_o  (upd_val),
      .reroute_o  (enet_reroute_o)
   );

   // mapped bits follow their source, unmapped bits keep their value
   assign pend_d = (pend_q & ~upd_mask) | (upd_val & upd_mask);

   irq_prio_enc #(
      .N_PEND (PEND_W),
      .L_W    (LVL_W),
      .V_W    (VEC_W),
      .V_BASE (VEC_BASE)
   ) u_enc (
      .pend_i (pend_d),
      .lvl_o  (lvl_d),
      .vec_o  (vec_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         pend_q <= '0;
         ipl_q  <= '0;
         vec_q  <= '0;
      end else begin
         mode_q <= mode_i;
         pend_q <= pend_d;
         ipl_q  <= lvl_d;
         vec_q  <= vec_d;
      end
   end

   assign ipl_o = ipl_q;
   assign vec_o = vec_q;

endmodule

// File: rtl/irq_prio_router_chk.sv
module irq_prio_router_chk #(
   parameter int unsigned HOLD_CYC = 8,
   parameter int unsigned CNT_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_q,
   input logic             enet_req_i,
   input logic             ser_req_i,
   input logic             nmi_strobe_i,
   input logic [CNT_W-1:0] nmi_cnt,
   input logic [2:0]       ipl_o,
   input logic [7:0]       vec_o,
   input logic             enet_reroute_o
);

   assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ipl_o == 3'd0) |-> (vec_o == 8'd0));

   assert_vec_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ipl_o != 3'd0) |-> (vec_o == {5'd0, ipl_o} + 8'd24));

   assert_reroute_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> !enet_reroute_o);

   assert_reroute_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> (enet_reroute_o == enet_req_i));

   assert_serial_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ser_req_i |=> (ipl_o >= 3'd4));

   assert_nmi_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_strobe_i |=> (ipl_o == 3'd7));

   assert_hold_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_cnt <= CNT_W'(HOLD_CYC - 1));

   assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |=> (ipl_o == 3'd0 && vec_o == 8'd0));

endmodule

bind irq_prio_router irq_prio_router_chk #(
   .HOLD_CYC (HOLD_CYC),
   .CNT_W    (CNT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode_q         (mode_q),
   .enet_req_i     (enet_req_i),
   .ser_req_i      (ser_req_i),
   .nmi_strobe_i   (nmi_strobe_i),
   .nmi_cnt        (nmi_cnt),
   .ipl_o          (ipl_o),
   .vec_o          (vec_o),
   .enet_reroute_o (enet_reroute_o)
);

// File: tb/irq_prio_router_bench.sv
module irq_prio_router_bench;

   localparam int unsigned CLK_HZ = 80;
   localparam int          HOLD   = CLK_HZ / 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_i = 1'b0;
   logic       io0 = 1'b0, io1 = 1'b0, enet = 1'b0, ser = 1'b0, strobe = 1'b0;
   logic [2:0] ipl_o;
   logic [7:0] vec_o;
   logic       reroute_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // bench model state
   logic [7:0] pend_m = '0;
   logic       mode_m = 1'b0;
   int         cnt_m  = 0;

   always #4 clk = ~clk;

   irq_prio_router #(.CLK_HZ(CLK_HZ)) u_irq_prio_router (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_i         (mode_i),
      .io0_req_i      (io0),
      .io1_req_i      (io1),
      .enet_req_i     (enet),
      .ser_req_i      (ser),
      .nmi_strobe_i   (strobe),
      .ipl_o          (ipl_o),
      .vec_o          (vec_o),
      .enet_reroute_o (reroute_o)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_lvl();
      for (int i = 7; i >= 0; i--) if (pend_m[i]) return i + 1;
      return 0;
   endfunction

   function automatic int exp_vec();
      for (int i = 7; i >= 0; i--) if (pend_m[i]) return i + 25;
      return 0;
   endfunction

   // one clock edge, advance the model, then compare just after the edge
   task automatic step(input string tag);
      logic nsrc;
      @(posedge clk);
      nsrc = strobe | (cnt_m != 0);
      if (mode_m) begin
         pend_m[0] = io0; pend_m[1] = io1; pend_m[3] = ser; pend_m[6] = nsrc;
      end else begin
         pend_m[5] = io0; pend_m[1] = io1; pend_m[2] = enet;
         pend_m[3] = ser; pend_m[6] = nsrc;
      end
      if (strobe) cnt_m = HOLD - 1;
      else if (cnt_m != 0) cnt_m = cnt_m - 1;
      mode_m = mode_i;
      #1;
      chk(tag, "ipl", int'(ipl_o), exp_lvl());
      chk(tag, "vec", int'(vec_o), exp_vec());
      chk("R2", "reroute", int'(reroute_o), int'(mode_m & enet));
   endtask

   task automatic set_reqs(input logic [3:0] v);
      {ser, enet, io1, io0} = v;
   endtask

   task automatic do_reset();
      #1 rst_n = 1'b0;
      pend_m = '0; mode_m = 1'b0; cnt_m = 0;
      #1;
      chk("R8", "ipl in reset", int'(ipl_o), 0);
      chk("R8", "vec in reset", int'(vec_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #400_000;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R8", "reset ipl", int'(ipl_o), 0);
      chk("R6", "reset vec", int'(vec_o), 0);
      chk("R2", "reset reroute", int'(reroute_o), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 sweep: high mode from a clean register
      mode_i = 1'b1;
      step("R9");
      for (int v = 0; v < 16; v++) begin
         set_reqs(4'(v));
         step("R1");
      end
      set_reqs(4'd0);
      step("R6");

      // R3 sweep: low mode
      mode_i = 1'b0;
      step("R9");
      for (int v = 0; v < 16; v++) begin
         set_reqs(4'(v));
         step("R3");
      end
      // R4: falling request clears its bit
      set_reqs(4'b1000);
      step("R4");
      set_reqs(4'd0);
      step("R4");

      // R10: output does not move before the next edge
      ser = 1'b1;
      #2;
      chk("R10", "ipl before edge", int'(ipl_o), 0);
      step("R10");
      chk("R10", "ipl after edge", int'(ipl_o), 4);
      ser = 1'b0;
      step("R5");

      // R9: mode change keeps stale bit 5
      io0 = 1'b1;
      step("R3");
      mode_i = 1'b1;
      step("R9");
      io0 = 1'b0;
      step("R9");
      chk("R9", "stale bit5 level", int'(ipl_o), 6);
      do_reset();
      step("R8");
      chk("R8", "stale bit cleared", int'(ipl_o), 0);

      // R7: single strobe window length
      mode_i = 1'b0;
      strobe = 1'b1;
      step("R7");
      strobe = 1'b0;
      for (int k = 1; k < HOLD + 3; k++) step("R7");
      // R7: restart during the window
      strobe = 1'b1;
      step("R7");
      strobe = 1'b0;
      for (int k = 0; k < 4; k++) step("R7");
      strobe = 1'b1;
      step("R7");
      strobe = 1'b0;
      for (int k = 1; k < HOLD + 2; k++) step("R7");
      // R8: reset cancels a window
      strobe = 1'b1;
      step("R7");
      strobe = 1'b0;
      step("R7");
      do_reset();
      for (int k = 0; k < HOLD; k++) step("R8");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule